// File: doc/BRIEF.md
# Peer Vector Routing Table

This block keeps a small routing table for a shared-memory messaging node. For each of a fixed number of peers it records how many interrupt vectors that peer has registered. It also holds the highest peer number registered so far, the node's own peer number, and whether the shared memory region has been attached. A doorbell decoder asks it, combinationally, whether a given destination peer and vector pair may be signalled.

All updates arrive as one kind of setup message, offered on a valid/ready handshake with at most one message per cycle. Each message carries a signed peer position and a flag that says whether an event channel comes with it. The block works out what the message means from those two fields. A message with no channel either assigns the node's own number or retires a peer. A message with a channel either attaches the shared region or adds one vector to a peer. Any message the table cannot hold is dropped and sets a sticky error flag.

Top module: `pvr_table`

## Requirements
- R1: After a synchronous reset, `local_id` reads -1 (all ones), `max_peer` reads 0, every peer's vector count is 0, `shm_attached` and `cfg_error` are low, and `msg_ready` is high from the first cycle after reset is released.
- R2: An accepted message without a channel, whose position is in 0..NUM_PEERS-1 and names a peer with no vectors, sets `local_id` to that position on the next cycle. No vector count changes.
- R3: An accepted message without a channel, for an in-range peer that has one or more vectors, resets that peer's count to 0. `local_id` and `max_peer` keep their values.
- R4: An accepted message with a channel and position -1 (all ones in two's complement) sets `shm_attached` and resets `max_peer` to 0. Vector counts are kept.
- R5: An accepted message with a channel and an in-range position, for a peer holding fewer than MAX_VECS vectors, adds one vector. The new vector's index equals the old count.
- R6: A successful add raises `max_peer` to the position when the position is larger. Otherwise `max_peer` is lowered only by R4.
- R7: An add for a peer that already holds MAX_VECS vectors changes nothing except setting `cfg_error`.
- R8: A position of NUM_PEERS or more, a negative position other than -1 with a channel, or any negative position without a channel changes nothing except setting `cfg_error`. The flag stays set until reset.
- R9: `lookup_ok` is high, in the same cycle, exactly when `lookup_dest` <= `max_peer` and `lookup_vec` is below the destination's vector count.
- R10: A cycle with `msg_valid` low changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| msg_valid | input | 1 | A setup message is offered |
| msg_ready | output | 1 | The table takes a message this cycle |
| msg_pos | input | POS_W | Signed peer position of the message |
| msg_has_chan | input | 1 | The message carries an event channel |
| lookup_dest | input | DEST_W | Destination peer to check |
| lookup_vec | input | VEC_W | Vector number to check |
| lookup_ok | output | 1 | The destination/vector pair is routable |
| local_id | output | POS_W | The node's own peer number, -1 when unassigned |
| max_peer | output | IDX_W | Highest registered peer number |
| shm_attached | output | 1 | The shared region has been attached |
| cfg_error | output | 1 | Sticky flag for a dropped message |

## Verification
The bench aims at the places where the message meaning depends on stored state. The same no-channel message for one peer assigns the node's number before that peer has vectors and retires the peer afterwards. A design that decoded on position alone would therefore overwrite `local_id` when it should retire the peer, or retire a peer it should have named. The attach message is sent after peers are registered, to confirm that `max_peer` falls to 0 and so hides peers whose counts are still held. Adds are pushed past the vector limit, and positions of 16, -2 and far out of range are sent. A design that wrapped a counter or aliased the index would make stale pairs routable, and the sweeps of `lookup_ok` catch that, including destinations that alias onto peer 0 once truncated.

// File: rtl/pvr_pkg.sv
package pvr_pkg;
  typedef enum logic [2:0] {
    MK_NONE,
    MK_SET_ID,
    MK_GONE,
    MK_ATTACH,
    MK_ADD,
    MK_REJECT
  } msg_kind_e;
endpackage

// File: rtl/pvr_classify.sv
module pvr_classify
  import pvr_pkg::*;
#(
  parameter int NUM_PEERS = 16,
  parameter int MAX_VECS  = 1,
  parameter int POS_W     = 8,
  parameter int CNT_W     = 1
) (
  input  logic             valid,
  input  logic [POS_W-1:0] pos,
  input  logic             has_chan,
  input  logic [CNT_W-1:0] cur_cnt,
  output msg_kind_e        kind
);
  localparam logic [POS_W:0]   LIMIT = (POS_W+1)'(NUM_PEERS);
  localparam logic [CNT_W-1:0] VCAP  = CNT_W'(MAX_VECS);

  logic is_neg, is_minus1, in_range;

  assign is_neg    = pos[POS_W-1];
  assign is_minus1 = &pos;
  assign in_range  = !is_neg && ({1'b0, pos} < LIMIT);

  always_comb begin
    kind = MK_NONE;
    if (valid) begin
      if (has_chan) begin
        if (is_minus1)      kind = MK_ATTACH;
        else if (!in_range) kind = MK_REJECT;
        else if (cur_cnt < VCAP) kind = MK_ADD;
        else                kind = MK_REJECT;
      end else begin
        if (!in_range)           kind = MK_REJECT;
        else if (cur_cnt == '0)  kind = MK_SET_ID;
        else                     kind = MK_GONE;
      end
    end
  end
endmodule

// File: rtl/pvr_count_bank.sv
module pvr_count_bank #(
  parameter int NUM_PEERS = 16,
  parameter int MAX_VECS  = 1,
  parameter int IDX_W     = 4,
  parameter int CNT_W     = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc_en,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [CNT_W-1:0] rd_cnt,
  input  logic [IDX_W-1:0] lk_idx,
  output logic [CNT_W-1:0] lk_cnt
);
  logic [CNT_W-1:0] cnt_q [NUM_PEERS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_PEERS; i++) cnt_q[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_PEERS; i++) begin
        if (wr_idx == IDX_W'(i)) begin
          if (clr_en)      cnt_q[i] <= '0;
          else if (inc_en) cnt_q[i] <= cnt_q[i] + 1'b1;
        end
      end
    end
  end

  always_comb begin
    rd_cnt = '0;
    lk_cnt = '0;
    for (int i = 0; i < NUM_PEERS; i++) begin
      if (rd_idx == IDX_W'(i)) rd_cnt = cnt_q[i];
      if (lk_idx == IDX_W'(i)) lk_cnt = cnt_q[i];
    end
  end

  generate
    for (genvar g = 0; g < NUM_PEERS; g++) begin : g_chk
      assert_count_bound_R7: assert property (@(posedge clk) disable iff (rst)
        cnt_q[g] <= CNT_W'(MAX_VECS));
      assert_gone_clears_R3: assert property (@(posedge clk) disable iff (rst)
        (clr_en && wr_idx == IDX_W'(g)) |=> (cnt_q[g] == '0));
      assert_add_steps_R5: assert property (@(posedge clk) disable iff (rst)
        (inc_en && !clr_en && wr_idx == IDX_W'(g)) |=> (cnt_q[g] == $past(cnt_q[g]) + 1'b1));
    end
  endgenerate
endmodule

// File: rtl/pvr_lookup.sv
module pvr_lookup #(
  parameter int DEST_W = 16,
  parameter int VEC_W  = 8,
  parameter int IDX_W  = 4,
  parameter int CNT_W  = 1
) (
  input  logic [DEST_W-1:0] dest,
  input  logic [VEC_W-1:0]  vec,
  input  logic [IDX_W-1:0]  max_peer,
  input  logic [CNT_W-1:0]  dest_cnt,
  output logic              ok
);
  localparam int DW = (DEST_W > IDX_W) ? DEST_W : IDX_W;
  localparam int VW = (VEC_W > CNT_W) ? VEC_W : CNT_W;

  logic [DW-1:0] dest_e, max_e;
  logic [VW-1:0] vec_e, cnt_e;

  always_comb begin
    dest_e = '0; dest_e[DEST_W-1:0] = dest;
    max_e  = '0; max_e[IDX_W-1:0]   = max_peer;
    vec_e  = '0; vec_e[VEC_W-1:0]   = vec;
    cnt_e  = '0; cnt_e[CNT_W-1:0]   = dest_cnt;
    ok = (dest_e <= max_e) && (vec_e < cnt_e);
  end
endmodule

// File: rtl/pvr_table.sv
module pvr_table
  import pvr_pkg::*;
#(
  parameter int NUM_PEERS = 16,
  parameter int MAX_VECS  = 1,
  parameter int POS_W     = 8,
  parameter int DEST_W    = 16,
  parameter int VEC_W     = 8,
  localparam int IDX_W    = (NUM_PEERS > 1) ? $clog2(NUM_PEERS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              msg_valid,
  output logic              msg_ready,
  input  logic [POS_W-1:0]  msg_pos,
  input  logic              msg_has_chan,
  input  logic [DEST_W-1:0] lookup_dest,
  input  logic [VEC_W-1:0]  lookup_vec,
  output logic              lookup_ok,
  output logic [POS_W-1:0]  local_id,
  output logic [IDX_W-1:0]  max_peer,
  output logic              shm_attached,
  output logic              cfg_error
);
  localparam int CNT_W = $clog2(MAX_VECS + 1);

  logic             ready_q, shm_q, err_q;
  logic [POS_W-1:0] local_q;
  logic [IDX_W-1:0] max_q;
  logic             accept;
  logic [IDX_W-1:0] wr_idx, lk_idx;
  logic [CNT_W-1:0] rd_cnt, lk_cnt;
  msg_kind_e        kind;

  assign accept = msg_valid && ready_q;
  assign wr_idx = msg_pos[IDX_W-1:0];
  assign lk_idx = lookup_dest[IDX_W-1:0];

  pvr_classify #(.NUM_PEERS(NUM_PEERS), .MAX_VECS(MAX_VECS), .POS_W(POS_W), .CNT_W(CNT_W)) u_classify (
    .valid(accept), .pos(msg_pos), .has_chan(msg_has_chan), .cur_cnt(rd_cnt), .kind(kind)
  );

  pvr_count_bank #(.NUM_PEERS(NUM_PEERS), .MAX_VECS(MAX_VECS), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_bank (
    .clk(clk), .rst(rst),
    .inc_en(kind == MK_ADD), .clr_en(kind == MK_GONE),
    .wr_idx(wr_idx), .rd_idx(wr_idx), .rd_cnt(rd_cnt),
    .lk_idx(lk_idx), .lk_cnt(lk_cnt)
  );

  pvr_lookup #(.DEST_W(DEST_W), .VEC_W(VEC_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_lookup (
    .dest(lookup_dest), .vec(lookup_vec), .max_peer(max_q), .dest_cnt(lk_cnt), .ok(lookup_ok)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ready_q <= 1'b0;
      shm_q   <= 1'b0;
      err_q   <= 1'b0;
      local_q <= '1;
      max_q   <= '0;
    end else begin
      ready_q <= 1'b1;
      unique case (kind)
        MK_SET_ID: local_q <= msg_pos;
        MK_ATTACH: begin
          shm_q <= 1'b1;
          max_q <= '0;
        end
        MK_ADD:    if (wr_idx > max_q) max_q <= wr_idx;
        MK_REJECT: err_q <= 1'b1;
        default: ;
      endcase
    end
  end

  assign msg_ready    = ready_q;
  assign local_id     = local_q;
  assign max_peer     = max_q;
  assign shm_attached = shm_q;
  assign cfg_error    = err_q;

  assert_ready_R10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> msg_ready);
  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !accept |=> ($stable(local_id) && $stable(max_peer) && $stable(shm_attached) && $stable(cfg_error)));
  assert_attach_R4: assert property (@(posedge clk) disable iff (rst)
    (accept && msg_has_chan && (&msg_pos)) |=> (max_peer == '0 && shm_attached));
  assert_max_monotone_R6: assert property (@(posedge clk) disable iff (rst)
    !(accept && msg_has_chan && (&msg_pos)) |=> (max_peer >= $past(max_peer)));
  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    cfg_error |=> cfg_error);
  assert_id_on_nochan_R2: assert property (@(posedge clk) disable iff (rst)
    !(accept && !msg_has_chan) |=> $stable(local_id));
  assert_lookup_needs_vec_R9: assert property (@(posedge clk) disable iff (rst)
    lookup_ok |-> (lk_cnt != '0));
endmodule

// File: tb/tb_pvr_table.sv
`timescale 1ns/1ps
module tb_pvr_table;
  localparam int NP = 16, MV = 3, PW = 8, DW = 16, VW = 8, IW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic msg_valid = 1'b0, msg_has_chan = 1'b0;
  logic [PW-1:0] msg_pos = '0;
  logic [DW-1:0] lookup_dest = '0;
  logic [VW-1:0] lookup_vec = '0;
  logic msg_ready, lookup_ok, shm_attached, cfg_error;
  logic [PW-1:0] local_id;
  logic [IW-1:0] max_peer;

  always #2 clk = ~clk;

  pvr_table #(.NUM_PEERS(NP), .MAX_VECS(MV), .POS_W(PW), .DEST_W(DW), .VEC_W(VW)) dut (
    .clk(clk), .rst(rst), .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_pos(msg_pos), .msg_has_chan(msg_has_chan),
    .lookup_dest(lookup_dest), .lookup_vec(lookup_vec), .lookup_ok(lookup_ok),
    .local_id(local_id), .max_peer(max_peer), .shm_attached(shm_attached), .cfg_error(cfg_error)
  );

  integer nchk = 0, nbad = 0;
  bit done = 1'b0;
  integer mcnt [NP];
  integer mlocal, mmax;
  bit mshm, merr;

  task automatic chk(string tag, string what, logic signed [31:0] act, logic signed [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic bit mlook(int d, int v);
    return (d <= mmax) && (d < NP) && (v < mcnt[d]);
  endfunction

  task automatic model_reset();
    for (int i = 0; i < NP; i++) mcnt[i] = 0;
    mlocal = -1; mmax = 0; mshm = 0; merr = 0;
  endtask

  task automatic model_msg(int pos, bit ch);
    if (ch) begin
      if (pos == -1) begin mshm = 1; mmax = 0; end
      else if (pos >= 0 && pos < NP) begin
        if (mcnt[pos] < MV) begin
          mcnt[pos]++;
          if (pos > mmax) mmax = pos;
        end else merr = 1;
      end else merr = 1;
    end else begin
      if (pos >= 0 && pos < NP) begin
        if (mcnt[pos] == 0) mlocal = pos;
        else mcnt[pos] = 0;
      end else merr = 1;
    end
  endtask

  task automatic check_state(string tag);
    chk(tag, "local_id", $signed(local_id), mlocal);
    chk(tag, "max_peer", {28'd0, max_peer}, mmax);
    chk(tag, "shm_attached", {31'd0, shm_attached}, {31'd0, mshm});
    chk(tag, "cfg_error", {31'd0, cfg_error}, {31'd0, merr});
    chk(tag, "msg_ready", {31'd0, msg_ready}, 1);
  endtask

  // One clock: drive at the falling edge, check the lookup before the rising
  // edge, update the model on the rising edge, check registered state after it.
  task automatic step(string tag, bit v, int pos, bit ch, int d, int vec);
    @(negedge clk);
    msg_valid    = v;
    msg_pos      = pos[PW-1:0];
    msg_has_chan = ch;
    lookup_dest  = d[DW-1:0];
    lookup_vec   = vec[VW-1:0];
    #1;
    chk(tag, $sformatf("lookup_ok d=%0d v=%0d", d, vec), {31'd0, lookup_ok}, {31'd0, mlook(d, vec)});
    @(posedge clk);
    if (v) model_msg(pos, ch);
    #1;
    check_state(tag);
  endtask

  task automatic sweep(string tag);
    for (int d = 0; d < NP + 2; d++)
      for (int v = 0; v <= MV; v++)
        step(tag, 1'b0, 0, 1'b0, d, v);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; msg_valid = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    model_reset();
    step("R1", 1'b0, 0, 1'b0, 0, 0);
  endtask

  initial begin
    model_reset();
    do_reset();
    sweep("R1");

    step("R2", 1'b1, 3, 1'b0, 3, 0);          // own number becomes 3
    step("R4", 1'b1, -1, 1'b1, 0, 0);         // attach region
    step("R5", 1'b1, 0, 1'b1, 0, 0);
    step("R5", 1'b1, 0, 1'b1, 0, 1);
    step("R6", 1'b1, 3, 1'b1, 3, 0);
    step("R6", 1'b1, 5, 1'b1, 5, 0);
    step("R5", 1'b1, 5, 1'b1, 5, 1);
    step("R5", 1'b1, 5, 1'b1, 5, 2);
    step("R7", 1'b1, 5, 1'b1, 5, 3);          // fourth vector refused
    step("R6", 1'b1, 2, 1'b1, 2, 0);          // lower id keeps max at 5
    sweep("R9");

    step("R3", 1'b1, 5, 1'b0, 5, 0);          // peer 5 retires
    step("R3", 1'b0, 0, 1'b0, 5, 0);
    step("R2", 1'b1, 5, 1'b0, 5, 0);          // empty again: own number 5
    step("R4", 1'b1, -1, 1'b1, 3, 0);         // max back to 0, peer 3 hidden
    step("R9", 1'b0, 0, 1'b0, 0, 1);
    step("R6", 1'b1, 1, 1'b1, 1, 0);
    step("R10", 1'b0, 7, 1'b1, 16, 0);        // idle, aliasing dest
    sweep("R9");

    do_reset();
    step("R8", 1'b1, 16, 1'b1, 0, 0);
    step("R8", 1'b1, 0, 1'b1, 0, 0);          // still works, flag sticky
    sweep("R8");
    do_reset();
    step("R8", 1'b1, -2, 1'b1, 0, 0);
    do_reset();
    step("R8", 1'b1, -1, 1'b0, 0, 0);
    do_reset();
    step("R8", 1'b1, 100, 1'b0, 0, 0);
    step("R10", 1'b0, 0, 1'b0, 0, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nbad++;
      $display("FAIL R10 watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
      $finish;
    end
  end
endmodule